// File: doc/BRIEF.md
# OFDM Packet Start Qualifier

This block sits at the front of a sample-clocked OFDM receiver. It decides when the downstream chain begins to process a packet. There are two kinds of event. The first is a coarse detection pulse, which comes from an on-chip energy/correlation detector, from an off-chip detector pin, or from both. The second is a threshold-crossing pulse from a long-preamble correlator. Configuration inputs select how the two kinds of event are combined. A coarse detection can be made mandatory. A long-correlator crossing can be made mandatory. The long crossing can be required as a pair of crossings exactly 64 samples apart.

After a coarse detection, a programmable delay counts off samples before processing may start. The block also runs a 16-bit sample-timing counter. The counter starts from zero at the coarse detection and is loaded with a programmable preset when the long-correlation event qualifies. A second, shorter delay measured from that qualifying long event produces the strobe that starts coarse frequency-offset estimation.

A packet-done input or the synchronous reset returns everything to idle. Only cycles with the sample-valid strobe high count as samples.

Top module: `ofdm_pkt_qual`

## Requirements
- R1: A coarse detection is taken from `int_det` only while `cfg_int_en` is 1, and from `ext_det` only while `cfg_ext_en` is 1. A pulse on a disabled source leaves `active` at 0.
- R2: With `cfg_need_coarse`=1 and `cfg_need_long`=0, `proc_start` is high for one cycle. That cycle follows the valid sample that comes `cfg_start_dly` samples after the coarse-detection sample. A delay of 0 means the cycle right after the coarse sample.
- R3: With `cfg_need_long`=1, `proc_start` waits for both conditions: the coarse delay has expired (when coarse is required) and a qualifying long event has occurred. It fires in the cycle after the later of the two samples.
- R4: With `cfg_need_coarse`=0, a qualifying long event alone starts processing. `proc_start` fires in the cycle after that sample.
- R5: With `cfg_need_coarse`=1, long crossings seen before any coarse detection are ignored.
- R6: With `cfg_need_pair`=1, a long event qualifies only when a crossing arrives exactly 64 valid samples after an earlier pending crossing. A crossing at any other spacing becomes the new pending crossing.
- R7: If 64 valid samples pass after a pending crossing without a second one, the pending crossing is dropped. A later crossing opens a fresh window.
- R8: `timing_cnt` becomes 0 on the coarse-detection sample and then rises by 1 per valid sample. It holds on cycles without `smp_valid` and reads 0 while `active` is 0.
- R9: On the qualifying long-event sample, `timing_cnt` is loaded with `cfg_time_preset`. It continues counting from there.
- R10: `cfo_start` is high for one cycle. That cycle follows the valid sample that comes `cfg_cfo_dly` samples after the qualifying long event.
- R11: `rst` or `pkt_done` clears the counter, all pending crossings and the delays. In the next cycle `active`, `timing_cnt`, `proc_start` and `cfo_start` are 0.
- R12: Between clears, `proc_start` and `cfo_start` each fire at most once. Later coarse or long events have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | One input sample this cycle |
| pkt_done | input | 1 | End of packet, return to idle |
| int_det | input | 1 | Coarse detection from internal detector |
| ext_det | input | 1 | Coarse detection from external pin |
| long_hit | input | 1 | Long-correlator threshold crossing |
| cfg_int_en | input | 1 | Accept internal coarse detection |
| cfg_ext_en | input | 1 | Accept external coarse detection |
| cfg_need_coarse | input | 1 | Coarse detection mandatory |
| cfg_need_long | input | 1 | Long-correlation event mandatory |
| cfg_need_pair | input | 1 | Long event needs two crossings 64 samples apart |
| cfg_start_dly | input | 7 | Samples from coarse detection to processing start |
| cfg_cfo_dly | input | 6 | Samples from long event to CFO estimation start |
| cfg_time_preset | input | 16 | Counter value loaded on the long event |
| proc_start | output | 1 | Start-of-processing strobe |
| cfo_start | output | 1 | Start of coarse frequency-offset estimation |
| timing_cnt | output | 16 | Per-packet sample-timing counter |
| active | output | 1 | A packet is being tracked |

## Verification
The start-of-processing strobe and the frequency-offset strobe can fall in the same cycle. This happens when the long event is the last condition for starting and the offset delay is 0. The bench provokes this with the long crossing arriving after the coarse delay has expired and the offset delay set to 0. The scoreboard pushes both expected sample numbers as the same value and checks that each strobe pops its own queue on that sample. A second collision is the counter load on the long-event sample while an earlier coarse start is still counting. The bench checks this by reading the preset value directly after that sample.

// File: rtl/ofdm_pq_pkg.sv
package ofdm_pq_pkg;

    // Per-packet progress flags of the qualifier
    typedef struct packed {
        logic seen;     // coarse detection taken
        logic dly_ok;   // start delay expired
        logic long_ok;  // long event qualified
        logic started;  // processing strobe issued
    } pq_flags_t;

    localparam int unsigned PQ_PAIR_GAP = 64;

endpackage

// File: rtl/ofdm_pq_coarse.sv
module ofdm_pq_coarse (
    input  logic smp_valid,
    input  logic int_det,
    input  logic ext_det,
    input  logic int_en,
    input  logic ext_en,
    input  logic seen,
    output logic first
);
    logic raw;

    assign raw   = (int_en & int_det) | (ext_en & ext_det);
    assign first = smp_valid & raw & ~seen;
endmodule

// File: rtl/ofdm_pq_delay.sv
// One-shot sample delay: hit on the sample LIMIT samples after arm
module ofdm_pq_delay #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         smp_valid,
    input  logic         arm,
    input  logic [W-1:0] limit,
    output logic         hit
);
    typedef struct packed {
        logic         run;
        logic         done;
        logic [W-1:0] idx;
    } dly_st_t;

    dly_st_t q, d;
    logic [W-1:0] idx_now;
    logic         live;

    always_comb begin
        d       = q;
        idx_now = q.run ? W'(q.idx + 1'b1) : '0;
        live    = q.run | (arm & ~q.done);
        hit     = smp_valid & live & (idx_now == limit);
        if (smp_valid && live) begin
            if (hit) begin
                d.run  = 1'b0;
                d.done = 1'b1;
                d.idx  = '0;
            end else begin
                d.run = 1'b1;
                d.idx = idx_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/ofdm_pq_pair.sv
// Long-event qualifier: single crossing or a pair exactly GAP samples apart
module ofdm_pq_pair #(
    parameter int unsigned GAP = 64
) (
    input  logic clk,
    input  logic clr,
    input  logic smp_valid,
    input  logic enable,
    input  logic need_pair,
    input  logic hit_in,
    output logic qual
);
    localparam int unsigned GW = $clog2(GAP + 1);

    typedef struct packed {
        logic          pend;
        logic [GW-1:0] gap;
    } pair_st_t;

    pair_st_t q, d;
    logic [GW-1:0] gap_now;
    logic          at_gap;

    assign gap_now = GW'(q.gap + 1'b1);
    assign at_gap  = q.pend & (gap_now == GW'(GAP));

    always_comb begin
        d    = q;
        qual = 1'b0;
        if (smp_valid && enable) begin
            if (!need_pair) begin
                qual = hit_in;
                d    = '0;
            end else if (hit_in) begin
                if (at_gap) begin
                    qual = 1'b1;
                    d    = '0;
                end else begin
                    d.pend = 1'b1;
                    d.gap  = '0;
                end
            end else if (q.pend) begin
                if (at_gap) d = '0;
                else        d.gap = gap_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/ofdm_pkt_qual.sv
module ofdm_pkt_qual #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned DLY_W    = 7,
    parameter int unsigned CFO_W    = 6,
    parameter int unsigned PAIR_GAP = ofdm_pq_pkg::PQ_PAIR_GAP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             pkt_done,
    input  logic             int_det,
    input  logic             ext_det,
    input  logic             long_hit,
    input  logic             cfg_int_en,
    input  logic             cfg_ext_en,
    input  logic             cfg_need_coarse,
    input  logic             cfg_need_long,
    input  logic             cfg_need_pair,
    input  logic [DLY_W-1:0] cfg_start_dly,
    input  logic [CFO_W-1:0] cfg_cfo_dly,
    input  logic [CNT_W-1:0] cfg_time_preset,
    output logic             proc_start,
    output logic             cfo_start,
    output logic [CNT_W-1:0] timing_cnt,
    output logic             active
);
    import ofdm_pq_pkg::*;

    typedef struct packed {
        pq_flags_t        fl;
        logic [CNT_W-1:0] cnt;
        logic             start_p;
        logic             cfo_p;
    } top_st_t;

    top_st_t q, d;

    logic clr;
    logic coarse_now;
    logic seen_now;
    logic pair_en;
    logic long_qual;
    logic dly_hit;
    logic cfo_hit;
    logic dly_ok_now;
    logic long_ok_now;
    logic trig;
    logic go;

    assign clr = rst | pkt_done;

    ofdm_pq_coarse u_coarse (
        .smp_valid (smp_valid),
        .int_det   (int_det),
        .ext_det   (ext_det),
        .int_en    (cfg_int_en),
        .ext_en    (cfg_ext_en),
        .seen      (q.fl.seen),
        .first     (coarse_now)
    );

    assign seen_now = q.fl.seen | coarse_now;
    assign pair_en  = (~cfg_need_coarse | seen_now) & ~q.fl.long_ok;

    ofdm_pq_pair #(.GAP(PAIR_GAP)) u_pair (
        .clk       (clk),
        .clr       (clr),
        .smp_valid (smp_valid),
        .enable    (pair_en),
        .need_pair (cfg_need_pair),
        .hit_in    (long_hit),
        .qual      (long_qual)
    );

    ofdm_pq_delay #(.W(DLY_W)) u_start_dly (
        .clk       (clk),
        .clr       (clr),
        .smp_valid (smp_valid),
        .arm       (coarse_now),
        .limit     (cfg_start_dly),
        .hit       (dly_hit)
    );

    ofdm_pq_delay #(.W(CFO_W)) u_cfo_dly (
        .clk       (clk),
        .clr       (clr),
        .smp_valid (smp_valid),
        .arm       (long_qual),
        .limit     (cfg_cfo_dly),
        .hit       (cfo_hit)
    );

    assign dly_ok_now  = q.fl.dly_ok | dly_hit;
    assign long_ok_now = q.fl.long_ok | long_qual;
    assign trig        = cfg_need_coarse ? dly_ok_now : (dly_ok_now | long_ok_now);
    assign go          = smp_valid & ~q.fl.started & trig & (~cfg_need_long | long_ok_now);

    always_comb begin
        d            = q;
        d.fl.seen    = seen_now;
        d.fl.dly_ok  = dly_ok_now;
        d.fl.long_ok = long_ok_now;
        d.fl.started = q.fl.started | go;
        d.start_p    = go;
        d.cfo_p      = cfo_hit;
        if (long_qual) begin
            d.cnt = cfg_time_preset;
        end else if (coarse_now && !q.fl.long_ok) begin
            d.cnt = '0;
        end else if (smp_valid && (q.fl.seen || q.fl.long_ok)) begin
            d.cnt = CNT_W'(q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) q <= '0;
        else     q <= d;
    end

    assign proc_start = q.start_p;
    assign cfo_start  = q.cfo_p;
    assign timing_cnt = q.cnt;
    assign active     = q.fl.seen | q.fl.long_ok;
endmodule

// File: rtl/ofdm_pkt_qual_chk.sv
module ofdm_pkt_qual_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             pkt_done,
    input logic             proc_start,
    input logic             cfo_start,
    input logic [CNT_W-1:0] timing_cnt,
    input logic             active
);
    // R11
    clear_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> (timing_cnt == '0 && !active && !proc_start && !cfo_start));

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !pkt_done) |=> $stable(timing_cnt));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> timing_cnt == '0);

    // R2
    start_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
        proc_start |-> $past(smp_valid));

    // R10
    cfo_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
        cfo_start |-> $past(smp_valid));

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        proc_start |=> !proc_start);

    // R12
    start_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        proc_start |-> active);
endmodule

bind ofdm_pkt_qual ofdm_pkt_qual_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .pkt_done   (pkt_done),
    .proc_start (proc_start),
    .cfo_start  (cfo_start),
    .timing_cnt (timing_cnt),
    .active     (active)
);

// File: tb/ofdm_pkt_qual_bench.sv
module ofdm_pkt_qual_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic        pkt_done = 1'b0;
    logic        int_det = 1'b0;
    logic        ext_det = 1'b0;
    logic        long_hit = 1'b0;
    logic        cfg_int_en = 1'b1;
    logic        cfg_ext_en = 1'b1;
    logic        cfg_need_coarse = 1'b1;
    logic        cfg_need_long = 1'b0;
    logic        cfg_need_pair = 1'b0;
    logic [6:0]  cfg_start_dly = 7'd5;
    logic [5:0]  cfg_cfo_dly = 6'd3;
    logic [15:0] cfg_time_preset = 16'd100;
    logic        proc_start;
    logic        cfo_start;
    logic [15:0] timing_cnt;
    logic        active;

    int checks = 0;
    int errors = 0;
    int cur_sid = 0;
    int exp_st[$];
    int exp_cf[$];

    always #5 clk = ~clk;

    ofdm_pkt_qual u_ofdm_pkt_qual (
        .clk             (clk),
        .rst             (rst),
        .smp_valid       (smp_valid),
        .pkt_done        (pkt_done),
        .int_det         (int_det),
        .ext_det         (ext_det),
        .long_hit        (long_hit),
        .cfg_int_en      (cfg_int_en),
        .cfg_ext_en      (cfg_ext_en),
        .cfg_need_coarse (cfg_need_coarse),
        .cfg_need_long   (cfg_need_long),
        .cfg_need_pair   (cfg_need_pair),
        .cfg_start_dly   (cfg_start_dly),
        .cfg_cfo_dly     (cfg_cfo_dly),
        .cfg_time_preset (cfg_time_preset),
        .proc_start      (proc_start),
        .cfo_start       (cfo_start),
        .timing_cnt      (timing_cnt),
        .active          (active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected sample numbers as strobes appear
    always @(negedge clk) begin
        int e;
        #1;
        if (!rst) begin
            if (proc_start) begin
                if (exp_st.size() == 0) check(1'b0, "R12 unexpected proc_start", cur_sid, -1);
                else begin
                    e = exp_st.pop_front();
                    check(cur_sid == e, "R2/R3/R4 proc_start sample", cur_sid, e);
                end
            end
            if (cfo_start) begin
                if (exp_cf.size() == 0) check(1'b0, "R12 unexpected cfo_start", cur_sid, -1);
                else begin
                    e = exp_cf.pop_front();
                    check(cur_sid == e, "R10 cfo_start sample", cur_sid, e);
                end
            end
        end
    end

    task automatic smp(input bit i, input bit e, input bit l);
        smp_valid = 1'b1; int_det = i; ext_det = e; long_hit = l;
        @(posedge clk);
        cur_sid++;
        @(negedge clk);
        smp_valid = 1'b0; int_det = 1'b0; ext_det = 1'b0; long_hit = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) smp(1'b0, 1'b0, 1'b0);
    endtask

    task automatic hole(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk_cnt(input string req, input int exp);
        check(int'(timing_cnt) == exp, req, int'(timing_cnt), exp);
    endtask

    task automatic done_pkt(input string req);
        check(exp_st.size() == 0, {req, " missing proc_start"}, exp_st.size(), 0);
        check(exp_cf.size() == 0, {req, " missing cfo_start"}, exp_cf.size(), 0);
        exp_st.delete();
        exp_cf.delete();
        pkt_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pkt_done = 1'b0;
        check(!active, "R11 active after pkt_done", active, 0);
        chk_cnt("R11 counter after pkt_done", 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        int l;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check(!proc_start && !cfo_start, "R11 strobes at reset", proc_start, 0);
        chk_cnt("R11 counter at reset", 0);
        check(!active, "R11 active at reset", active, 0);

        // R2 / R8: delay 5, counting with holes in the stream
        c = cur_sid + 1;
        exp_st.push_back(c + 5);
        smp(1'b1, 1'b0, 1'b0);
        chk_cnt("R8 zero on coarse", 0);
        idle(2);
        hole(3);
        chk_cnt("R8 hold without valid", 2);
        idle(6);
        chk_cnt("R8 count per sample", 8);
        done_pkt("R2");

        // R2: zero delay
        cfg_start_dly = 7'd0;
        c = cur_sid + 1;
        exp_st.push_back(c);
        smp(1'b1, 1'b0, 1'b0);
        idle(3);
        done_pkt("R2 zero delay");

        // R1: source enables
        cfg_start_dly = 7'd1;
        cfg_int_en = 1'b0;
        smp(1'b1, 1'b0, 1'b0);
        idle(4);
        check(!active, "R1 internal disabled", active, 0);
        c = cur_sid + 1;
        exp_st.push_back(c + 1);
        smp(1'b0, 1'b1, 1'b0);
        idle(3);
        done_pkt("R1 external");
        cfg_int_en = 1'b1;
        cfg_ext_en = 1'b0;
        smp(1'b0, 1'b1, 1'b0);
        idle(3);
        check(!active, "R1 external disabled", active, 0);
        c = cur_sid + 1;
        exp_st.push_back(c + 1);
        smp(1'b1, 1'b0, 1'b0);
        idle(3);
        done_pkt("R1 internal");
        cfg_ext_en = 1'b1;

        // R3 / R9 / R10: long after delay
        cfg_need_long = 1'b1;
        cfg_start_dly = 7'd2;
        c = cur_sid + 1;
        smp(1'b1, 1'b0, 1'b0);
        idle(5);
        l = cur_sid + 1;
        exp_st.push_back(l);
        exp_cf.push_back(l + 3);
        smp(1'b0, 1'b0, 1'b1);
        chk_cnt("R9 preset load", 100);
        idle(2);
        chk_cnt("R9 count after preset", 102);
        idle(3);
        done_pkt("R3");

        // R3: long before delay expires
        cfg_start_dly = 7'd10;
        c = cur_sid + 1;
        smp(1'b1, 1'b0, 1'b0);
        idle(2);
        exp_cf.push_back(cur_sid + 1 + 3);
        exp_st.push_back(c + 10);
        smp(1'b0, 1'b0, 1'b1);
        idle(10);
        done_pkt("R3 early long");

        // R5: long crossings before coarse ignored; R12: single start
        cfg_start_dly = 7'd2;
        smp(1'b0, 1'b0, 1'b1);
        idle(2);
        smp(1'b0, 1'b0, 1'b1);
        check(!active, "R5 long without coarse", active, 0);
        chk_cnt("R5 counter untouched", 0);
        c = cur_sid + 1;
        smp(1'b1, 1'b0, 1'b0);
        idle(3);
        exp_st.push_back(c + 4);
        exp_cf.push_back(c + 7);
        smp(1'b0, 1'b0, 1'b1);
        idle(4);
        smp(1'b1, 1'b0, 1'b1);
        smp(1'b0, 1'b1, 1'b1);
        idle(8);
        done_pkt("R12");

        // R4: long alone starts processing
        cfg_need_coarse = 1'b0;
        l = cur_sid + 1;
        exp_st.push_back(l);
        exp_cf.push_back(l + 3);
        smp(1'b0, 1'b0, 1'b1);
        chk_cnt("R4 preset on long-only start", 100);
        idle(5);
        done_pkt("R4");

        // R6: exact 64-sample pair, with holes in between
        cfg_need_pair = 1'b1;
        l = cur_sid + 1;
        smp(1'b0, 1'b0, 1'b1);
        idle(30);
        hole(5);
        idle(33);
        check(!active, "R6 single crossing not enough", active, 0);
        exp_st.push_back(l + 64);
        exp_cf.push_back(l + 67);
        smp(1'b0, 1'b0, 1'b1);
        idle(5);
        done_pkt("R6 pair");

        // R6: spacing 63 does not qualify, becomes new pending crossing
        smp(1'b0, 1'b0, 1'b1);
        idle(62);
        l = cur_sid + 1;
        smp(1'b0, 1'b0, 1'b1);
        check(!active, "R6 spacing 63 rejected", active, 0);
        idle(63);
        exp_st.push_back(l + 64);
        exp_cf.push_back(l + 67);
        smp(1'b0, 1'b0, 1'b1);
        idle(5);
        done_pkt("R6 rearm");

        // R7: spacing 65, window expired, fresh window from late crossing
        smp(1'b0, 1'b0, 1'b1);
        idle(64);
        l = cur_sid + 1;
        smp(1'b0, 1'b0, 1'b1);
        check(!active, "R7 late crossing rejected", active, 0);
        idle(63);
        exp_st.push_back(l + 64);
        exp_cf.push_back(l + 67);
        smp(1'b0, 1'b0, 1'b1);
        idle(5);
        done_pkt("R7");

        // R11: pkt_done and rst abort a pending start
        cfg_need_pair = 1'b0;
        cfg_need_coarse = 1'b1;
        cfg_need_long = 1'b0;
        cfg_start_dly = 7'd20;
        smp(1'b1, 1'b0, 1'b0);
        idle(5);
        done_pkt("R11 abort");
        idle(25);
        check(!active, "R11 no restart after abort", active, 0);
        smp(1'b1, 1'b0, 1'b0);
        idle(3);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_cnt("R11 counter after rst", 0);
        check(!active, "R11 active after rst", active, 0);
        idle(25);

        // R3 / R10: both strobes in one cycle
        cfg_need_long = 1'b1;
        cfg_start_dly = 7'd2;
        cfg_cfo_dly = 6'd0;
        smp(1'b1, 1'b0, 1'b0);
        idle(4);
        l = cur_sid + 1;
        exp_st.push_back(l);
        exp_cf.push_back(l);
        smp(1'b0, 1'b0, 1'b1);
        check(proc_start && cfo_start, "R10 coincident strobes", {proc_start, cfo_start}, 3);
        idle(3);
        done_pkt("R10 coincident");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule